// File: doc/BRIEF.md
# Multifunction ALU for a Small RISC Core

A purely combinational integer unit for a compact load/store processor. It takes two register operands and a short immediate, and returns one result word along with a zero flag and a sign flag that branch logic can use. It covers add, subtract, signed set-less-than, the four bitwise functions AND, OR, XOR and NOR, shifts, and the load-upper-immediate placement. Address generation for loads and stores uses the same adder: a base register plus the sign-extended offset.

The operation comes from an 8-bit control word that is split into four subfields rather than given as a flat opcode. Bits [7:6] pick the function class: 00 shift, 01 set-less-than, 10 arithmetic, 11 logic. Bit [5] is the subtract select. Bits [4:2] steer the shifter. Bits [1:0] pick the logic function: 00 AND, 01 OR, 10 XOR, 11 NOR. Two side inputs choose the second operand. When `use_imm_i` is low the second operand is `b_i`. When it is high the second operand is the immediate, which is zero-extended, or sign-extended when `sext_i` is high.

Top module: `mf_alu`

## Requirements
- R1: With class 10 and bit [5] low, `result_o` equals the first operand plus the second operand, modulo 2^WIDTH.
- R2: With class 10 and bit [5] high, `result_o` equals the first operand minus the second operand, modulo 2^WIDTH.
- R3: With class 01 and bit [5] high, `result_o` is 1 when the first operand is smaller than the second as signed two's-complement numbers, and 0 otherwise. Overflow of the subtraction never changes the answer, and all bits above bit 0 are 0.
- R4: With class 11, the logic code in bits [1:0] selects the function of the two operands: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R5: With `use_imm_i` low, the second operand is `b_i`, and `imm_i` and `sext_i` have no effect on `result_o`. With `use_imm_i` high, the second operand is `imm_i` widened to WIDTH: zero-extended when `sext_i` is low, sign-extended when it is high.
- R6: With class 00 and shift bits [3:2] = 11, `result_o` is `imm_i` in the upper IMM_W bits and zeros below.
- R7: With class 00, shift bits [3:2] select 00 logical left, 01 logical right, 10 arithmetic right. The shift amount comes from the low log2(WIDTH) bits of `imm_i` when bit [4] is 0, and from the same bits of `b_i` when bit [4] is 1.
- R8: An add with the sign-extended immediate gives base plus offset as an effective address, wrapping modulo 2^WIDTH, for both positive and negative offsets.
- R9: `zero_o` is high exactly when `result_o` is all zeros, and `neg_o` equals the top bit of `result_o`, for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand (register value or base address) |
| b_i | input | WIDTH | Second register operand |
| imm_i | input | IMM_W | Immediate field; its low bits also carry a constant shift amount |
| use_imm_i | input | 1 | Use the immediate as the second operand |
| sext_i | input | 1 | Sign-extend the immediate (otherwise zero-extend) |
| ctrl_i | input | 8 | Control word: class [7:6], subtract [5], shift [4:2], logic [1:0] |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Top bit of the result |

## Verification
The bench builds the ALU with WIDTH = 8 and IMM_W = 4. At that size every pair of register operands can be swept for add, subtract, set-less-than and all four logic codes. The sweep therefore reaches every signed-overflow case of the comparison and every wrap of the adder. Every base value is also combined with every immediate under both extension modes, and every operand is shifted by every amount of each shift kind from both amount sources. Expected values come from integer arithmetic in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_SLT   = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_LOGIC = 2'b11
  } alu_cls_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOR = 2'b11
  } alu_lg_e;

  typedef enum logic [1:0] {
    SH_SLL = 2'b00,
    SH_SRL = 2'b01,
    SH_SRA = 2'b10,
    SH_LUI = 2'b11
  } alu_sh_e;

  typedef struct packed {
    alu_cls_e cls;
    logic     sub;
    logic     amt_from_b;
    alu_sh_e  sh;
    alu_lg_e  lg;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_operand.sv
module alu_operand #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             sext_i,
  output logic [WIDTH-1:0] opnd_o
);
  localparam int EXT_W = WIDTH - IMM_W;

  logic ext_bit;

  always_comb begin
    ext_bit = sext_i & imm_i[IMM_W-1];
    opnd_o  = use_imm_i ? {{EXT_W{ext_bit}}, imm_i} : b_i;
    if (use_imm_i && !sext_i) begin
      a_r5_zext: assert (opnd_o[WIDTH-1:IMM_W] == '0);
    end
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             lt_o
);
  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
    // sign disagreement decides directly; otherwise the difference cannot overflow
    lt_o  = (a_i[WIDTH-1] ^ b_i[WIDTH-1]) ? a_i[WIDTH-1] : sum_o[WIDTH-1];
    if (sub_i) begin
      a_r2_sub_inverse: assert ((sum_o + b_i) == a_i);
      a_r3_signed_lt: assert (lt_o == ($signed(a_i) < $signed(b_i)));
    end else begin
      a_r1_add_inverse: assert ((sum_o - b_i) == a_i);
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]      a_i,
  input  logic [WIDTH-1:0]      b_i,
  input  alu_pkg::alu_lg_e      lg_i,
  output logic [WIDTH-1:0]      out_o
);
  import alu_pkg::*;

  always_comb begin
    unique case (lg_i)
      LG_AND:  out_o = a_i & b_i;
      LG_OR:   out_o = a_i | b_i;
      LG_XOR:  out_o = a_i ^ b_i;
      default: out_o = ~(a_i | b_i);
    endcase
    if (lg_i == LG_XOR) begin
      a_r4_xor_undo: assert ((out_o ^ b_i) == a_i);
    end
    if (lg_i == LG_NOR) begin
      a_r4_nor_disjoint: assert ((out_o & (a_i | b_i)) == '0);
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              amt_from_b_i,
  input  alu_pkg::alu_sh_e  sh_i,
  output logic [WIDTH-1:0]  out_o
);
  import alu_pkg::*;

  localparam int SH_W = $clog2(WIDTH);
  localparam int LO_W = WIDTH - IMM_W;

  logic [SH_W-1:0]  amt;
  logic             fill;
  logic [WIDTH-1:0] lft [SH_W+1];
  logic [WIDTH-1:0] rgt [SH_W+1];

  assign amt    = amt_from_b_i ? b_i[SH_W-1:0] : imm_i[SH_W-1:0];
  assign fill   = (sh_i == SH_SRA) & a_i[WIDTH-1];
  assign lft[0] = a_i;
  assign rgt[0] = a_i;

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int D = 2 ** g;
    assign lft[g+1] = amt[g] ? {lft[g][WIDTH-1-D:0], {D{1'b0}}} : lft[g];
    assign rgt[g+1] = amt[g] ? {{D{fill}}, rgt[g][WIDTH-1:D]}   : rgt[g];
  end

  always_comb begin
    unique case (sh_i)
      SH_SLL:  out_o = lft[SH_W];
      SH_SRL,
      SH_SRA:  out_o = rgt[SH_W];
      default: out_o = {imm_i, {LO_W{1'b0}}};
    endcase
    if (sh_i == SH_SLL) begin
      a_r7_sll_keeps: assert ((out_o >> amt) == (a_i & ({WIDTH{1'b1}} >> amt)));
    end
  end
endmodule

// File: rtl/mf_alu.sv
module mf_alu #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             sext_i,
  input  logic [7:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             neg_o
);
  import alu_pkg::*;

  alu_ctrl_t        ctl;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] sum;
  logic             lt;
  logic [WIDTH-1:0] lg_res;
  logic [WIDTH-1:0] sh_res;

  assign ctl = alu_ctrl_t'(ctrl_i);

  alu_operand #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opnd (
    .b_i(b_i), .imm_i(imm_i), .use_imm_i(use_imm_i), .sext_i(sext_i), .opnd_o(opnd_b)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(opnd_b), .sub_i(ctl.sub), .sum_o(sum), .lt_o(lt)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(opnd_b), .lg_i(ctl.lg), .out_o(lg_res)
  );

  alu_shift #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_shift (
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .amt_from_b_i(ctl.amt_from_b),
    .sh_i(ctl.sh), .out_o(sh_res)
  );

  always_comb begin
    unique case (ctl.cls)
      CLS_SHIFT: result_o = sh_res;
      CLS_SLT:   result_o = {{(WIDTH-1){1'b0}}, lt};
      CLS_ARITH: result_o = sum;
      default:   result_o = lg_res;
    endcase
    zero_o = (result_o == '0);
    neg_o  = result_o[WIDTH-1];
  end
endmodule

// File: tb/sim_mf_alu.sv
`timescale 1ns/1ps
module sim_mf_alu;
  localparam int W = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0]  a, b, res;
  logic [IW-1:0] imm;
  logic          use_imm, sext, zf, nf;
  logic [7:0]    ctrl;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  mf_alu #(.WIDTH(W), .IMM_W(IW)) u0 (
    .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm), .sext_i(sext),
    .ctrl_i(ctrl), .result_o(res), .zero_o(zf), .neg_o(nf)
  );

  function automatic int sv(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  task automatic chk(input string req, input int exp);
    n_chk++;
    if (res !== exp[W-1:0]) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d imm=%0d ctrl=%b got=%0d exp=%0d", req, a, b, imm, ctrl, res, exp[W-1:0]);
    end
    n_chk++;
    if (zf !== (exp[W-1:0] == 0) || nf !== exp[W-1]) begin
      n_bad++;
      $display("FAIL R9 flags got z=%b n=%b exp z=%b n=%b", zf, nf, exp[W-1:0] == 0, exp[W-1]);
    end
  endtask

  task automatic apply(input int av, input int bv, input int iv, input bit ui, input bit se, input logic [7:0] c);
    a = av[W-1:0]; b = bv[W-1:0]; imm = iv[IW-1:0]; use_imm = ui; sext = se; ctrl = c;
    #1;
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    apply(0, 0, 0, 0, 0, 8'h00);
    chk("R9 reset-state zero", 0);
    // register-register sweeps; imm and sext carry junk that must be ignored (R5)
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        apply(x, y, x ^ y, 0, y[0], 8'b10_0_000_00);
        chk("R1 add / R5 imm ignored", (x + y) & 255);
        apply(x, y, x + y, 0, x[0], 8'b10_1_000_00);
        chk("R2 sub", (x - y) & 255);
        apply(x, y, y, 0, 1, 8'b01_1_000_00);
        chk("R3 slt", (sv(x) < sv(y)) ? 1 : 0);
        apply(x, y, x, 0, 0, 8'b11_0_000_00);
        chk("R4 and", x & y);
        apply(x, y, x, 0, 1, 8'b11_0_000_01);
        chk("R4 or", x | y);
        apply(x, y, y, 0, 0, 8'b11_0_000_10);
        chk("R4 xor", x ^ y);
        apply(x, y, y, 0, 1, 8'b11_0_000_11);
        chk("R4 nor", ~(x | y) & 255);
      end
    end
    // immediate forms
    for (int x = 0; x < 256; x++) begin
      for (int i = 0; i < 16; i++) begin
        for (int s = 0; s < 2; s++) begin
          int ie;
          ie = (s == 1 && i >= 8) ? i + 240 : i;
          apply(x, 255 - x, i, 1, s[0], 8'b10_0_000_00);
          chk(s == 1 ? "R8 effective address" : "R5 zext add", (x + ie) & 255);
          apply(x, 0, i, 1, s[0], 8'b01_1_000_00);
          chk("R3 slti / R5 ext", (sv(x) < sv(ie)) ? 1 : 0);
          apply(x, 85, i, 1, s[0], 8'b11_0_000_00);
          chk("R5 andi", x & ie);
          apply(x, 85, i, 1, s[0], 8'b11_0_000_01);
          chk("R5 ori", x | ie);
          apply(x, 85, i, 1, s[0], 8'b11_0_000_10);
          chk("R5 xori", x ^ ie);
        end
      end
    end
    // shifts, amount from imm then from b
    for (int x = 0; x < 256; x++) begin
      for (int n = 0; n < 8; n++) begin
        for (int src = 0; src < 2; src++) begin
          int iv, bv;
          iv = (src == 0) ? n : (7 - n) + 8;
          bv = (src == 1) ? n + 8 * x[2:0] : 7 - n;
          apply(x, bv, iv, 0, 0, {2'b00, 1'b0, src[0], 2'b00, 2'b00});
          chk("R7 sll", (x << n) & 255);
          apply(x, bv, iv, 0, 0, {2'b00, 1'b0, src[0], 2'b01, 2'b00});
          chk("R7 srl", x >> n);
          apply(x, bv, iv, 0, 0, {2'b00, 1'b0, src[0], 2'b10, 2'b00});
          chk("R7 sra", (sv(x) >>> n) & 255);
        end
      end
    end
    for (int i = 0; i < 16; i++) begin
      apply(i * 13, 200 - i, i, 0, 1, 8'b00_0_011_00);
      chk("R6 lui", i * 16);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule